// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is a single-byte SPI master controlled through a small byte-addressed register window. Software loads a byte to send, then writes the go bit. The engine clocks eight bits out on the serial data output and samples the serial data input on the opposite SCK edges. When the last edge has passed, it stores the received byte, sets a ready flag and raises its interrupt line. There is no queue. Each byte needs its own go command, normally issued from the interrupt handler after it has collected the previous byte.

A configuration register sets the SCK rest level and selects which edge samples data. That edge bit is the inverse of the usual clock-phase bit, so the four standard SPI modes are: mode 0 = edge 1 / rest 0, mode 1 = edge 0 / rest 0, mode 2 = edge 1 / rest 1, mode 3 = edge 0 / rest 1. The same register selects least-significant-bit-first order, an internal loopback path and a port enable. An 8-bit divisor register sets the SCK frequency to the system clock divided by 4×(divisor+1).

The register read path is a plain multiplexer on the address. Only a selected read of the receive register has a side effect.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0 and `sck`, `mosi` and `irq` are low.
- R2: Register offsets are 0 config, 1 receive byte, 2 send byte, 3 command, 4 status and 6 divisor. Config keeps bits 4..0 only. Send byte and divisor read back in full. Offset 3 and the unused offsets 5 and 7 read 0.
- R3: Writing a value with bit 0 set to offset 3, while config bit 3 (enable) is 1 and no transfer runs, starts one 8-bit transfer of the send byte. With config bit 2 = 0, bits leave most-significant first and the first bit received lands in bit 7 of the receive byte.
- R4: With config bit 2 = 1, both directions are least-significant first: send bit 0 goes out first, and the first bit received lands in bit 0.
- R5: Config bit 1 is the SCK rest level. Config bit 4 = 1 samples on the leading edge (edge leaving the rest level) and launches on trailing edges. Config bit 4 = 0 launches on leading edges and samples on trailing ones. SCK sits at the rest level whenever no transfer runs.
- R6: With config bit 0 = 1, the serial output feeds the receive path and `miso` is ignored, so the receive byte equals the send byte.
- R7: The ready flag rises 32×(divisor+1) clock cycles after the edge that accepts the go write, so SCK runs at the clock divided by 4×(divisor+1).
- R8: Status bit 1 (busy) is set in the cycle after a go is accepted. It is still set in the first cycle in which ready is high, and it clears one cycle later.
- R9: Status bit 0 is the ready flag and `irq` follows it. A selected read of offset 1 clears both, unless a transfer completes in that same cycle.
- R10: With config bit 3 = 0, `sck` stays at the rest level, `mosi` is low and a go write starts nothing.
- R11: A go write or a send-byte write during a transfer does not restart or alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Level interrupt, high while a received byte is unread |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Counting from the clock edge that accepts the go write, the ready flag and `irq` are due exactly 32×(divisor+1) cycles later, busy is due to fall one cycle after that, and the cleared `irq` is due in the cycle after the selected receive read. The bench drives the bus on falling edges and counts falling edges from the accepting edge. It compares that count with the formula and samples status at the first ready cycle and again one cycle later. A behavioural slave follows SCK edges according to the selected mode, supplies a known byte and records the bits it sees on `mosi`. The expected received byte and the expected captured byte are computed from the bit-order and loopback rules alone.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
   localparam logic [REG_AW-1:0] RA_RXD  = 3'd1;
   localparam logic [REG_AW-1:0] RA_TXD  = 3'd2;
   localparam logic [REG_AW-1:0] RA_CTRL = 3'd3;
   localparam logic [REG_AW-1:0] RA_STAT = 3'd4;
   localparam logic [REG_AW-1:0] RA_DIV  = 3'd6;

   localparam int unsigned CB_GO   = 0;
   localparam int unsigned SB_RDY  = 0;
   localparam int unsigned SB_BUSY = 1;

   localparam int unsigned MODE_W = 5;

   // packed from bit 4 down to bit 0
   typedef struct packed {
      logic lead_sample;
      logic enable;
      logic lsb_first;
      logic idle_high;
      logic loopback;
   } mode_t;

endpackage

// File: rtl/spi_bit_rev.sv
module spi_bit_rev #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int unsigned CW = DIV_W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   // half SCK period is 2*(div+1) clocks, so the terminal count is 2*div+1
   assign limit = {div, 1'b1};
   assign tick  = run & (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              tick,
   input  logic              lead_sample,
   input  logic              lsb_first,
   input  logic              loopback,
   input  logic              miso,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              busy,
   output logic              shifting,
   output logic              done_now,
   output logic              phase,
   output logic              mosi_bit,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int unsigned EDGES = 2 * DATA_W;
   localparam int unsigned EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_shift_core: DATA_W must be at least 2");
   end

   logic              busy_q, done_q, phase_q;
   logic [EW-1:0]     edge_q;
   logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, rx_fin, tx_rev, rx_rev, rx_q;
   logic              lead_edge, sample_now, launch_now, in_bit;

   assign lead_edge  = ~edge_q[0];
   assign sample_now = tick & (lead_edge == lead_sample);
   // the first leading edge never launches: bit 0 is already on the wire
   assign launch_now = tick & (lead_edge != lead_sample) & (edge_q != '0);
   assign in_bit     = loopback ? tx_sh[DATA_W-1] : miso;
   assign rx_next    = {rx_sh[DATA_W-2:0], in_bit};
   assign rx_fin     = sample_now ? rx_next : rx_sh;
   assign done_now   = tick & (edge_q == LAST_EDGE);

   // the shifters always run MSB-first; LSB-first is a reversal at load and capture
   spi_bit_rev #(.W(DATA_W)) u_tx_rev (.din(tx_byte), .dout(tx_rev));
   spi_bit_rev #(.W(DATA_W)) u_rx_rev (.din(rx_fin),  .dout(rx_rev));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         phase_q <= 1'b0;
         edge_q  <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_q    <= '0;
      end else if (go) begin
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
         phase_q <= 1'b0;
         edge_q  <= '0;
         tx_sh   <= lsb_first ? tx_rev : tx_byte;
         rx_sh   <= '0;
      end else begin
         if (done_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
         end
         if (tick) begin
            phase_q <= ~phase_q;
            edge_q  <= done_now ? '0 : edge_q + 1'b1;
         end
         if (sample_now) begin
            rx_sh <= rx_next;
         end
         if (launch_now) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         end
         if (done_now) begin
            done_q <= 1'b1;
            rx_q   <= lsb_first ? rx_rev : rx_fin;
         end
      end
   end

   assign busy     = busy_q;
   assign shifting = busy_q & ~done_q;
   assign phase    = phase_q;
   assign mosi_bit = tx_sh[DATA_W-1];
   assign rx_byte  = rx_q;

   AST_BUSY_LINGER: assert property (@(posedge clk) disable iff (!rst_n)
      done_now |=> busy_q) else $error("busy fell with completion"); // R8
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !busy_q) else $error("busy held past completion"); // R8
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_byte_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   if (DATA_W < MODE_W) begin : g_bad_data_w
      $error("spi_byte_master: DATA_W too small for the config field");
   end
   if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div_w
      $error("spi_byte_master: DIV_W must lie in 1..DATA_W");
   end

   mode_t             mode_q;
   logic [DATA_W-1:0] txd_q;
   logic [DIV_W-1:0]  div_q;
   logic              rdy_q;

   logic              wr_hit, rd_rx, start_req, go;
   logic              busy, shifting, done_now, tick, phase, mosi_bit;
   logic [DATA_W-1:0] rx_byte;

   assign wr_hit    = bus_sel & bus_wr;
   assign rd_rx     = bus_sel & ~bus_wr & (bus_addr == RA_RXD);
   assign start_req = wr_hit & (bus_addr == RA_CTRL) & bus_wdata[CB_GO];
   assign go        = start_req & mode_q.enable & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         txd_q  <= '0;
         div_q  <= '0;
      end else if (wr_hit) begin
         case (bus_addr)
            RA_MODE: mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            RA_TXD:  txd_q  <= bus_wdata;
            RA_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   // completion wins over a read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
      end else if (done_now) begin
         rdy_q <= 1'b1;
      end else if (rd_rx) begin
         rdy_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_MODE: bus_rdata[MODE_W-1:0] = mode_q;
         RA_RXD:  bus_rdata = rx_byte;
         RA_TXD:  bus_rdata = txd_q;
         RA_STAT: begin
            bus_rdata[SB_BUSY] = busy;
            bus_rdata[SB_RDY]  = rdy_q;
         end
         RA_DIV:  bus_rdata[DIV_W-1:0] = div_q;
         default: bus_rdata = '0;
      endcase
   end

   spi_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (shifting),
      .div   (div_q),
      .tick  (tick)
   );

   spi_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .tick        (tick),
      .lead_sample (mode_q.lead_sample),
      .lsb_first   (mode_q.lsb_first),
      .loopback    (mode_q.loopback),
      .miso        (miso),
      .tx_byte     (txd_q),
      .busy        (busy),
      .shifting    (shifting),
      .done_now    (done_now),
      .phase       (phase),
      .mosi_bit    (mosi_bit),
      .rx_byte     (rx_byte)
   );

   assign sck  = mode_q.enable ? (mode_q.idle_high ^ phase) : mode_q.idle_high;
   assign mosi = mode_q.enable & mosi_bit;
   assign irq  = rdy_q;

   AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == mode_q.idle_high)) else $error("sck away from rest level"); // R5
   AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !mode_q.enable && !busy) |=> !busy) else $error("disabled port started"); // R10
   AST_RDY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_now |=> irq) else $error("no interrupt at completion"); // R9
   AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !done_now) |=> !irq) else $error("interrupt survived read"); // R9
endmodule

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq, sck, mosi;
   logic       miso;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   spi_byte_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
   );

   // behavioural slave
   logic [7:0] s_val = 8'h00;
   logic       s_idle = 1'b0;
   logic       s_cpha = 1'b0;
   int         l_cnt = 0, t_cnt = 0, l_base = 0, t_base = 0;
   logic [7:0] cap = 8'h00;

   always @(sck) begin
      if (sck != s_idle) begin
         l_cnt = l_cnt + 1;
         if (!s_cpha) cap = {cap[6:0], mosi};
      end else begin
         t_cnt = t_cnt + 1;
         if (s_cpha) cap = {cap[6:0], mosi};
      end
   end

   always @* begin
      int lr, tr, idx;
      lr  = l_cnt - l_base;
      tr  = t_cnt - t_base;
      idx = s_cpha ? ((lr == 0) ? 0 : lr - 1) : tr;
      miso = (idx >= 0 && idx < 8) ? s_val[7-idx] : 1'b0;
   end

   // mode, divisor, send byte, slave byte
   localparam logic [31:0] VECS [8] = '{
      32'h18_00_A5_3C, 32'h08_01_96_C3, 32'h1A_02_5A_81, 32'h0A_00_F0_0F,
      32'h1C_01_1E_B2, 32'h0E_03_C5_6D, 32'h19_00_3B_FF, 32'h0B_FF_E7_00
   };

   function automatic logic [7:0] rev8(input logic [7:0] x);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = x[7-i];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic arm(input logic [7:0] m, input logic [7:0] s);
      s_val = s; s_idle = m[1]; s_cpha = ~m[4];
      l_base = l_cnt; t_base = t_cnt;
   endtask

   task automatic run_vec(input logic [31:0] v);
      logic [7:0] m, d, t, s, st, rx, exp_rx;
      int n;
      string tag;
      m = v[31:24]; d = v[23:16]; t = v[15:8]; s = v[7:0];
      exp_rx = m[0] ? t : (m[2] ? rev8(s) : s);
      tag = m[0] ? "R6" : (m[2] ? "R4" : "R3");
      bus_write(3'd0, m);
      bus_write(3'd6, d);
      bus_write(3'd2, t);
      arm(m, s);
      bus_write(3'd3, 8'h01);
      peek(3'd4, st);
      chk(st[1] == 1'b1, "R8", "busy after go", st, 2);
      n = 0;
      while (!irq && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(n == 32 * (int'(d) + 1), "R7", "cycles to ready", n, 32 * (int'(d) + 1));
      peek(3'd4, st);
      chk(st == 8'h03, "R8", "busy at first ready cycle", st, 3);
      @(negedge clk);
      peek(3'd4, st);
      chk(st == 8'h01, "R8", "busy one cycle later", st, 1);
      bus_read(3'd1, rx);
      chk(rx == exp_rx, tag, "received byte", rx, exp_rx);
      chk(irq == 1'b0, "R9", "irq after receive read", irq, 0);
      chk(cap == (m[2] ? rev8(t) : t), "R5", "slave captured byte", cap, m[2] ? rev8(t) : t);
      chk(sck == m[1], "R5", "sck at rest after byte", sck, m[1]);
   endtask

   initial begin
      logic [7:0] rd;
      int n, bad;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
      chk(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
      for (int a = 0; a < 8; a++) begin
         peek(3'(a), rd);
         chk(rd == 8'h00, "R1", "register after reset", rd, 0);
      end

      for (int i = 0; i < 8; i++) run_vec(VECS[i]);

      // R10 disabled port, rest level high
      bus_write(3'd0, 8'h02);
      chk(sck == 1'b1, "R10", "sck rest while disabled", sck, 1);
      chk(mosi == 1'b0, "R10", "mosi while disabled", mosi, 0);
      bus_write(3'd3, 8'h01);
      bad = 0;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         peek(3'd4, rd);
         if (rd != 8'h00 || irq || sck != 1'b1 || mosi) bad++;
      end
      chk(bad == 0, "R10", "cycles with activity while disabled", bad, 0);

      // R11 go and send-byte writes during a transfer
      bus_write(3'd0, 8'h18);
      bus_write(3'd6, 8'h01);
      bus_write(3'd2, 8'h55);
      arm(8'h18, 8'h99);
      bus_write(3'd3, 8'h01);
      n = 0;
      repeat (10) begin @(negedge clk); n++; end
      bus_write(3'd2, 8'hAA); n += 2;
      bus_write(3'd3, 8'h01); n += 2;
      while (!irq && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(n == 64, "R11", "completion time with mid-transfer go", n, 64);
      chk(cap == 8'h55, "R11", "byte sent despite new send byte", cap, 8'h55);
      bus_read(3'd1, rd);
      chk(rd == 8'h99, "R11", "byte received", rd, 8'h99);
      bad = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (irq) bad++;
      end
      chk(bad == 0, "R11", "cycles with a second completion", bad, 0);

      // R2 readback
      peek(3'd2, rd); chk(rd == 8'hAA, "R2", "send byte readback", rd, 8'hAA);
      peek(3'd6, rd); chk(rd == 8'h01, "R2", "divisor readback", rd, 1);
      peek(3'd3, rd); chk(rd == 8'h00, "R2", "command reads zero", rd, 0);
      peek(3'd5, rd); chk(rd == 8'h00, "R2", "offset 5 reads zero", rd, 0);
      peek(3'd7, rd); chk(rd == 8'h00, "R2", "offset 7 reads zero", rd, 0);
      bus_write(3'd0, 8'hE0);
      peek(3'd0, rd); chk(rd == 8'h00, "R2", "config upper bits dropped", rd, 0);
      bus_write(3'd0, 8'hFF);
      peek(3'd0, rd); chk(rd == 8'h1F, "R2", "config readback", rd, 8'h1F);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule